// File: doc/BRIEF.md
# Integer Register-Register Execute Stage

This block is the execute step for 32-bit integer instructions that take two register operands, plus the two instructions that load an upper immediate (one alone, one added to the program counter). Each cycle it receives an instruction word, that instruction's PC and the two source operand values that an outside register file has already read. One clock edge later it presents the destination register index, the 32-bit result, a write strobe for the register file and a flag that marks the instruction as undefined.

Decoding is strict. Every function-select combination that is not defined for the chosen operation is rejected, and so is every major opcode outside the three that are handled. A rejected instruction never produces a write. Writes that target register 0 are also suppressed, so that register keeps its zero value. The block contains no register storage, no fetch logic and no memory path. It only decodes and computes.

Top module: `rvx_exec_unit`

## Requirements
- R1: While reset is asserted, and after reset until the first registered instruction, `wr_en`, `bad_insn`, `wr_idx` and `wr_data` are all zero.
- R2: Major opcode `instr[6:0]` = 0110111 (upper-immediate load) gives `wr_data` = `instr` with bits [11:0] cleared.
- R3: Major opcode 0010111 (PC-relative upper immediate) gives `wr_data` = `pc` + (`instr` with bits [11:0] cleared), truncated to 32 bits.
- R4: Opcode 0110011 with `instr[14:12]`=000 gives `src_a`+`src_b` when `instr[31:25]`=0000000, and `src_a`−`src_b` when it is 0100000, both modulo 2^32.
- R5: Opcode 0110011 with sub-op 001 shifts left logically, with sub-op 101 and top field 0000000 shifts right logically, and with sub-op 101 and top field 0100000 shifts right arithmetically. The shift amount is `src_b[4:0]` only, and `src_b[31:5]` has no effect.
- R6: Sub-op 010 writes 1 when `src_a` < `src_b` as signed 32-bit numbers and 0 otherwise. Sub-op 011 does the same comparison unsigned.
- R7: Sub-op 100 gives bitwise XOR, sub-op 110 gives bitwise OR, and sub-op 111 gives bitwise AND.
- R8: `bad_insn` is 1 for any major opcode other than the three above. For opcode 0110011 it is also 1 when the top field is not 0000000, except that 0100000 is accepted with sub-ops 000 and 101.
- R9: When `bad_insn` is 1, `wr_en` is 0.
- R10: `wr_idx` is `instr[11:7]`. `wr_en` is 0 whenever that index is 0.
- R11: All outputs are registered. The outputs seen after a rising edge reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| src_a | input | 32 | First source operand value |
| src_b | input | 32 | Second source operand value |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 32 | Result value |
| wr_en | output | 1 | Register-file write strobe |
| bad_insn | output | 1 | Undefined-instruction flag |

## Verification
The bench builds the block with its default parameters: a 32-bit data path and a five-stage shifter. At that width the bench can reach the sign boundary operands 0x80000000 and 0x7FFFFFFF, shift amounts 0 and 31 with the upper bits of the amount operand set, and AUIPC wrap-around past 2^32. It sweeps every sub-op against several accepted and rejected top-field values, tries unknown opcodes and register-0 destinations, and then runs a long stream of random instructions. A behavioural model in the bench checks every one of these cases on the cycle after it is issued.

// File: rtl/rvx_pkg.sv
package rvx_pkg;
  localparam int XLEN   = 32;
  localparam int SHW    = $clog2(XLEN);
  localparam int IDXW   = 5;
  localparam int UIMM_LO = 12;

  localparam logic [6:0] MAJ_REG   = 7'b0110011;
  localparam logic [6:0] MAJ_LUI   = 7'b0110111;
  localparam logic [6:0] MAJ_AUIPC = 7'b0010111;
  localparam logic [6:0] TOP_BASE  = 7'b0000000;
  localparam logic [6:0] TOP_ALT   = 7'b0100000;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU, OP_XOR,
    OP_SRL, OP_SRA, OP_OR, OP_AND, OP_LUI, OP_AUIPC
  } alu_op_e;
endpackage

// File: rtl/rvx_rst_sync.sv
module rvx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rvx_decode.sv
module rvx_decode
  import rvx_pkg::*;
(
  input  logic [6:0] maj,
  input  logic [2:0] sub,
  input  logic [6:0] top,
  output alu_op_e    op,
  output logic       illegal
);
  logic top_base, top_alt;

  assign top_base = (top == TOP_BASE);
  assign top_alt  = (top == TOP_ALT);

  always_comb begin
    op      = OP_ADD;
    illegal = 1'b0;
    unique case (maj)
      MAJ_LUI:   op = OP_LUI;
      MAJ_AUIPC: op = OP_AUIPC;
      MAJ_REG: begin
        unique case (sub)
          3'b000: begin
            op      = top_alt ? OP_SUB : OP_ADD;
            illegal = !(top_base || top_alt);
          end
          3'b101: begin
            op      = top_alt ? OP_SRA : OP_SRL;
            illegal = !(top_base || top_alt);
          end
          3'b001: begin op = OP_SLL;  illegal = !top_base; end
          3'b010: begin op = OP_SLT;  illegal = !top_base; end
          3'b011: begin op = OP_SLTU; illegal = !top_base; end
          3'b100: begin op = OP_XOR;  illegal = !top_base; end
          3'b110: begin op = OP_OR;   illegal = !top_base; end
          default: begin op = OP_AND; illegal = !top_base; end
        endcase
      end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/rvx_shifter.sv
module rvx_shifter #(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  dout
);
  logic [AW:0][W-1:0] stg;
  logic [W-1:0]       flipped_in;
  logic [W-1:0]       flipped_out;
  logic               fill;

  // A left shift is done as a right shift of the bit-reversed word.
  for (genvar b = 0; b < W; b++) begin : g_rev
    assign flipped_in[b]  = din[W-1-b];
    assign flipped_out[b] = stg[AW][W-1-b];
  end

  assign fill   = arith && !left && din[W-1];
  assign stg[0] = left ? flipped_in : din;

  for (genvar i = 0; i < AW; i++) begin : g_stage
    localparam int D = 1 << i;
    assign stg[i+1] = amt[i] ? {{D{fill}}, stg[i][W-1:D]} : stg[i];
  end

  assign dout = left ? flipped_out : stg[AW];
endmodule

// File: rtl/rvx_alu.sv
module rvx_alu
  import rvx_pkg::*;
(
  input  alu_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [XLEN-1:0]  pc,
  input  logic [31:UIMM_LO] uimm_hi,
  output logic [XLEN-1:0]  result
);
  logic            is_sub;
  logic [XLEN-1:0] add_b;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] uimm;
  logic [XLEN-1:0] shifted;
  logic            lt_s, lt_u;

  assign is_sub = (op == OP_SUB);
  assign add_b  = is_sub ? ~b : b;
  assign sum    = a + add_b + {{(XLEN-1){1'b0}}, is_sub};
  assign uimm   = {uimm_hi, {UIMM_LO{1'b0}}};
  assign lt_s   = $signed(a) < $signed(b);
  assign lt_u   = a < b;

  rvx_shifter #(.W(XLEN)) u_shift (
    .din   (a),
    .amt   (b[SHW-1:0]),
    .left  (op == OP_SLL),
    .arith (op == OP_SRA),
    .dout  (shifted)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:         result = sum;
      OP_SLL, OP_SRL, OP_SRA: result = shifted;
      OP_SLT:                 result = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU:                result = {{(XLEN-1){1'b0}}, lt_u};
      OP_XOR:                 result = a ^ b;
      OP_OR:                  result = a | b;
      OP_AND:                 result = a & b;
      OP_LUI:                 result = uimm;
      OP_AUIPC:               result = pc + uimm;
      default:                result = '0;
    endcase
  end
endmodule

// File: rtl/rvx_exec_unit.sv
module rvx_exec_unit
  import rvx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      instr,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  output logic [IDXW-1:0]  wr_idx,
  output logic [XLEN-1:0]  wr_data,
  output logic             wr_en,
  output logic             bad_insn
);
  logic            rst_sync_n;
  alu_op_e         dec_op;
  logic            dec_illegal;
  logic [XLEN-1:0] alu_res;

  logic [IDXW-1:0] idx_d, idx_q;
  logic [XLEN-1:0] data_d, data_q;
  logic            we_d, we_q;
  logic            bad_d, bad_q;

  rvx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rvx_decode u_dec (
    .maj     (instr[6:0]),
    .sub     (instr[14:12]),
    .top     (instr[31:25]),
    .op      (dec_op),
    .illegal (dec_illegal)
  );

  rvx_alu u_alu (
    .op      (dec_op),
    .a       (src_a),
    .b       (src_b),
    .pc      (pc),
    .uimm_hi (instr[31:UIMM_LO]),
    .result  (alu_res)
  );

  // next state
  always_comb begin
    idx_d  = instr[11:7];
    data_d = alu_res;
    bad_d  = dec_illegal;
    we_d   = !dec_illegal && (instr[11:7] != '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q  <= '0;
      data_q <= '0;
      we_q   <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      data_q <= data_d;
      we_q   <= we_d;
      bad_q  <= bad_d;
    end
  end

  assign wr_idx   = idx_q;
  assign wr_data  = data_q;
  assign wr_en    = we_q;
  assign bad_insn = bad_q;
endmodule

// File: rtl/rvx_exec_checker.sv
module rvx_exec_checker
  import rvx_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [IDXW-1:0] wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic            wr_en,
  input logic            bad_insn
);
  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  a_r9_bad_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    bad_insn |-> !wr_en);

  a_r10_x0_never_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx == '0) |-> !wr_en);

  a_r11_idx_follows: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (wr_idx == $past(instr[11:7])));

  a_r2_lui_value: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(instr[6:0]) == MAJ_LUI) |->
      (wr_data == {$past(instr[31:12]), 12'h000} && !bad_insn));

  a_r8_unknown_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(instr[6:0]) != MAJ_LUI && $past(instr[6:0]) != MAJ_AUIPC
            && $past(instr[6:0]) != MAJ_REG) |-> bad_insn);

  a_r4_add_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(instr[6:0]) == MAJ_REG && $past(instr[14:12]) == 3'b000
            && $past(instr[31:25]) == TOP_BASE) |->
      (wr_data == $past(src_a) + $past(src_b)));

  a_r6_compare_is_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(instr[6:0]) == MAJ_REG && $past(instr[14:13]) == 2'b01
            && !bad_insn) |-> (wr_data[XLEN-1:1] == '0));
endmodule

bind rvx_exec_unit rvx_exec_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .instr    (instr),
  .src_a    (src_a),
  .src_b    (src_b),
  .wr_idx   (wr_idx),
  .wr_data  (wr_data),
  .wr_en    (wr_en),
  .bad_insn (bad_insn)
);

// File: tb/sim_rvx_exec_unit.sv
`timescale 1ns/1ps
module sim_rvx_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr, pc, src_a, src_b;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic        wr_en, bad_insn;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  rvx_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc),
    .src_a(src_a), .src_b(src_b), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_en(wr_en), .bad_insn(bad_insn)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  task automatic model(input logic [31:0] ins, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b,
                       output bit ill, output logic [31:0] res, output string tag);
    logic [6:0] f7;
    logic [2:0] f3;
    int sh;
    f7 = ins[31:25];
    f3 = ins[14:12];
    sh = int'(b % 32);
    ill = 0;
    res = 32'h0;
    tag = "R8";
    if (ins[6:0] == 7'h37) begin
      res = ins & 32'hFFFF_F000; tag = "R2";
    end else if (ins[6:0] == 7'h17) begin
      res = p + (ins & 32'hFFFF_F000); tag = "R3";
    end else if (ins[6:0] == 7'h33) begin
      ill = !((f7 == 7'd0) || ((f3 == 3'd0 || f3 == 3'd5) && f7 == 7'd32));
      case (f3)
        3'd0: begin res = (f7 == 7'd32) ? a - b : a + b; tag = "R4"; end
        3'd1: begin res = a << sh; tag = "R5"; end
        3'd2: begin res = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R6"; end
        3'd3: begin res = (a < b) ? 1 : 0; tag = "R6"; end
        3'd4: begin res = a ^ b; tag = "R7"; end
        3'd5: begin
          res = (f7 == 7'd32) ? 32'($signed(a) >>> sh) : a >> sh; tag = "R5";
        end
        3'd6: begin res = a | b; tag = "R7"; end
        default: begin res = a & b; tag = "R7"; end
      endcase
      if (ill) tag = "R8";
    end else begin
      ill = 1;
    end
  endtask

  // drive at a falling edge, compare at the next falling edge (R11)
  task automatic apply(input logic [31:0] ins, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b);
    bit ill;
    logic [31:0] res;
    string tag;
    model(ins, p, a, b, ill, res, tag);
    instr = ins; pc = p; src_a = a; src_b = b;
    @(negedge clk);
    chk("R8", "bad_insn", {31'd0, bad_insn}, {31'd0, ill});
    chk(ill ? "R9" : "R10", "wr_en", {31'd0, wr_en},
        {31'd0, !ill && ins[11:7] != 5'd0});
    chk("R11", "wr_idx", {27'd0, wr_idx}, {27'd0, ins[11:7]});
    if (!ill) chk(tag, "wr_data", wr_data, res);
  endtask

  function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [2:0] f3,
                                        input logic [4:0] rd);
    return {f7, 5'd2, 5'd1, f3, rd, 7'h33};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [6:0] tops [5];
    tops[0] = 7'h00; tops[1] = 7'h20; tops[2] = 7'h01; tops[3] = 7'h40; tops[4] = 7'h7F;
    rst_n = 0; instr = 32'h0000_0537; pc = 0; src_a = 32'hFFFF_FFFF; src_b = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "wr_en", {31'd0, wr_en}, 0);
    chk("R1", "bad_insn", {31'd0, bad_insn}, 0);
    chk("R1", "wr_data", wr_data, 0);
    chk("R1", "wr_idx", {27'd0, wr_idx}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "wr_en after release", {31'd0, wr_en}, 0);
    chk("R1", "wr_data after release", wr_data, 0);
    @(negedge clk);
    @(negedge clk);

    // R2 / R3
    apply(32'hABCDE_FB7 & 32'hFFFF_FFFF | 32'h37, 32'h0, 0, 0);
    apply(32'h8000_0FB7, 32'h0, 0, 0);
    apply(32'h00001_097, 32'hFFFF_F000, 0, 0);     // AUIPC wraps to 0
    apply(32'hFFFFF_117, 32'h0000_2004, 0, 0);
    // R4 overflow
    apply(rtype(7'h00, 3'd0, 5'd3), 0, 32'h7FFF_FFFF, 32'h1);
    apply(rtype(7'h20, 3'd0, 5'd3), 0, 32'h0, 32'h1);
    apply(rtype(7'h20, 3'd0, 5'd3), 0, 32'h8000_0000, 32'h7FFF_FFFF);
    // R5 shift extremes, upper bits of src_b set
    apply(rtype(7'h00, 3'd1, 5'd4), 0, 32'h8000_0001, 32'hFFFF_FFE0);
    apply(rtype(7'h00, 3'd1, 5'd4), 0, 32'h8000_0001, 32'hFFFF_FFFF);
    apply(rtype(7'h00, 3'd5, 5'd4), 0, 32'h8000_0000, 32'h0000_001F);
    apply(rtype(7'h20, 3'd5, 5'd4), 0, 32'h8000_0000, 32'hABCD_EF1F);
    apply(rtype(7'h20, 3'd5, 5'd4), 0, 32'h7FFF_FFFF, 32'h0000_0020);
    apply(rtype(7'h20, 3'd5, 5'd4), 0, 32'h8000_0000, 32'h4);
    // R6 sign boundary
    apply(rtype(7'h00, 3'd2, 5'd5), 0, 32'h8000_0000, 32'h7FFF_FFFF);
    apply(rtype(7'h00, 3'd3, 5'd5), 0, 32'h8000_0000, 32'h7FFF_FFFF);
    apply(rtype(7'h00, 3'd3, 5'd5), 0, 32'h0, 32'h0);
    apply(rtype(7'h00, 3'd3, 5'd5), 0, 32'h0, 32'h8);
    apply(rtype(7'h00, 3'd2, 5'd5), 0, 32'h5, 32'h5);
    // R7
    apply(rtype(7'h00, 3'd4, 5'd6), 0, 32'hF0F0_1234, 32'h0FF0_FFFF);
    apply(rtype(7'h00, 3'd6, 5'd6), 0, 32'hF0F0_1234, 32'h0FF0_FFFF);
    apply(rtype(7'h00, 3'd7, 5'd6), 0, 32'hF0F0_1234, 32'h0FF0_FFFF);
    // R10 destination zero
    apply(rtype(7'h00, 3'd0, 5'd0), 0, 32'h11, 32'h22);
    apply(32'h1234_5037, 0, 0, 0);
    // R8 / R9 sweep of every sub-op with accepted and rejected top fields
    for (int f3 = 0; f3 < 8; f3++)
      for (int t = 0; t < 5; t++)
        apply(rtype(tops[t], 3'(f3), 5'd9), 0, 32'h8000_0000, 32'h7FFF_FFFF);
    // R8 unknown opcodes
    apply(32'h0000_0513, 0, 1, 2);
    apply(32'h0000_0F0F, 0, 1, 2);
    apply(32'h0000_04B3 ^ 32'h1, 0, 1, 2);
    apply(32'h0000_056F, 0, 1, 2);
    // random stream
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] r;
      logic [6:0]  maj;
      r = $urandom;
      case ($urandom % 8)
        0: maj = 7'h37;
        1: maj = 7'h17;
        2: maj = 7'(($urandom % 128));
        default: maj = 7'h33;
      endcase
      if (($urandom % 2) == 1) r[31:25] = (($urandom % 2) == 1) ? 7'h20 : 7'h00;
      apply({r[31:7], maj}, $urandom, $urandom, $urandom);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule